// File: doc/BRIEF.md
# Masked Base Address Decoder with Translation

This block is one target-side address window of a bus bridge. It holds a single programmable base register, and a fixed mask chosen at build time qualifies that register. System software sizes the window with the usual probe: it writes all ones, reads the register back, clears the type bits, inverts the result and adds one. Software then programs a base inside the space that it allocates.

For each incoming bus address, the block compares the masked upper bits with the masked base. It also checks that the access type matches the window's space (memory or I/O) and that the matching space enable is on. When all of these hold, it raises a hit.

The same mask controls translation. When translation is enabled for the window, the masked upper address bits are replaced by a fixed translation base before the address goes on to the local side. All bits outside the mask pass through unchanged. Only a fixed number of the highest address lines take part in decoding, and mask bits below that range are dropped.

Top module: `addr_image_decoder`

## Requirements
- R1: The 24-bit mask parameter applies to address bits 31:8 (mask bit k governs address bit k+8). A mask of 0xFFFFF0 gives a 4 KB window and a mask of 0xFFF000 gives a 1 MB window.
- R2: Only the top 20 address lines (bits 31:12) are decoded. Mask bits for address bits 11:8 are treated as 0, so these bits never affect hit, readback or translation.
- R3: After 0xFFFFFFFF is written, the readback holds ones in every decoded masked position and zeros in every other upper position.
- R4: Readback bits 7:0 are zero, except bit 0, which reads 1 for an I/O window and 0 for a memory window.
- R5: Base bits whose effective mask bit is 0 ignore writes and always read 0.
- R6: A hit requires (bus_addr & mask) == (base & mask) over bits 31:8.
- R7: A hit also requires that `bus_is_io` equals the window space (1 = I/O, 0 = memory) and that the matching enable is high: `io_en` for an I/O window, `mem_en` for a memory window.
- R8: When the effective mask is all zeros, the readback is 0x00000000 and `hit` stays 0.
- R9: With translation enabled, each masked upper address bit is replaced by the corresponding translation base bit.
- R10: With translation disabled, `xlat_addr` equals `bus_addr`.
- R11: Address bits outside the effective mask, including bits 7:0, reach `xlat_addr` unchanged.
- R12: After reset the base is 0. `cfg_rdata` is 0 whenever `cfg_rd` is low. A write takes effect on the clock edge where `cfg_wr` is high and is visible at readback from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe for the base register |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_rdata | output | 32 | Base register readback, zero when not reading |
| bus_addr | input | 32 | Incoming bus address |
| bus_is_io | input | 1 | Access type: 1 = I/O, 0 = memory |
| mem_en | input | 1 | Memory space enable |
| io_en | input | 1 | I/O space enable |
| hit | output | 1 | Address falls inside this window |
| xlat_addr | output | 32 | Address passed to the local side |

## Verification
Several rules are checked by assertions on every cycle. A hit never appears without the right access type and enable, or while the window is off. The base changes only on a write, and it then holds exactly the masked write data. Bits outside the mask always reach the translated output unchanged, and a window without translation passes the whole address through. Other behaviour can only be shown by the bench's directed scenarios across three differently built instances. These cover the exact window boundaries of the 4 KB and 1 MB images, the sizing readback values, the dropping of mask bits below the decoded range, and the concrete translated address.

// File: rtl/aid_pkg.sv
package aid_pkg;
  localparam int unsigned AID_ADDR_W    = 32;
  localparam int unsigned AID_MASK_W    = 24;
  localparam int unsigned AID_DEC_LINES = 20;

  typedef enum logic {
    SPACE_MEM = 1'b0,
    SPACE_IO  = 1'b1
  } aid_space_e;
endpackage

// File: rtl/aid_rst_sync.sv
module aid_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/aid_base_reg.sv
module aid_base_reg #(
  parameter int unsigned            MASK_W   = 24,
  parameter logic [MASK_W-1:0]      EFF_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MASK_W-1:0] wr_upper,
  output logic [MASK_W-1:0] base_q
);
  logic [MASK_W-1:0] base_d;

  always_comb begin
    base_d = wr_upper & EFF_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_q <= '0;
    else if (wr_en) base_q <= base_d;
  end

  AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_q)); // R12
  AST_BASE_TAKES_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_q == ($past(wr_upper) & EFF_MASK))); // R5
endmodule

// File: rtl/aid_match.sv
module aid_match #(
  parameter int unsigned       MASK_W   = 24,
  parameter logic [MASK_W-1:0] EFF_MASK = '1,
  parameter logic              IS_IO    = 1'b0
) (
  input  logic [MASK_W-1:0] addr_upper,
  input  logic [MASK_W-1:0] base_q,
  input  logic              bus_is_io,
  input  logic              mem_en,
  input  logic              io_en,
  output logic              hit
);
  localparam logic IMAGE_ON = |EFF_MASK;

  logic addr_eq;
  logic type_ok;
  logic space_on;

  always_comb begin
    addr_eq = ((addr_upper ^ base_q) & EFF_MASK) == '0;
    type_ok = (bus_is_io == IS_IO);
  end

  generate
    if (IS_IO) begin : g_io
      always_comb space_on = io_en;
    end else begin : g_mem
      always_comb space_on = mem_en;
    end
  endgenerate

  always_comb begin
    hit = IMAGE_ON && addr_eq && type_ok && space_on;
  end
endmodule

// File: rtl/aid_xlat.sv
module aid_xlat #(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       MASK_W    = 24,
  parameter logic [MASK_W-1:0] EFF_MASK  = '1,
  parameter logic              XLAT_EN   = 1'b0,
  parameter logic [MASK_W-1:0] XLAT_BASE = '0
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int unsigned LOW_W = ADDR_W - MASK_W;

  generate
    if (XLAT_EN) begin : g_xlat
      logic [MASK_W-1:0] upper_d;
      always_comb begin
        upper_d  = (XLAT_BASE & EFF_MASK) | (addr_in[ADDR_W-1:LOW_W] & ~EFF_MASK);
        addr_out = {upper_d, addr_in[LOW_W-1:0]};
      end
    end else begin : g_pass
      always_comb addr_out = addr_in;
    end
  endgenerate
endmodule

// File: rtl/addr_image_decoder.sv
module addr_image_decoder #(
  parameter int unsigned                      ADDR_W    = aid_pkg::AID_ADDR_W,
  parameter int unsigned                      MASK_W    = aid_pkg::AID_MASK_W,
  parameter int unsigned                      DEC_LINES = aid_pkg::AID_DEC_LINES,
  parameter logic [MASK_W-1:0]                MASK      = 24'hFFFFF0,
  parameter logic                             IS_IO     = aid_pkg::SPACE_MEM,
  parameter logic                             XLAT_EN   = 1'b0,
  parameter logic [MASK_W-1:0]                XLAT_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              cfg_rd,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_is_io,
  input  logic              mem_en,
  input  logic              io_en,
  output logic              hit,
  output logic [ADDR_W-1:0] xlat_addr
);
  localparam int unsigned       LOW_W    = ADDR_W - MASK_W;
  localparam int unsigned       DROP_W   = MASK_W - DEC_LINES;
  localparam logic [MASK_W-1:0] KEEP     = {MASK_W{1'b1}} << DROP_W;
  localparam logic [MASK_W-1:0] EFF_MASK = MASK & KEEP;
  localparam logic              IMAGE_ON = |EFF_MASK;
  localparam logic [ADDR_W-1:0] FULL_MASK = {EFF_MASK, {LOW_W{1'b0}}};

  logic              rst_sync_n;
  logic [MASK_W-1:0] base_q;
  logic [ADDR_W-1:0] rd_word;

  aid_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  aid_base_reg #(
    .MASK_W   (MASK_W),
    .EFF_MASK (EFF_MASK)
  ) u_base (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (cfg_wr),
    .wr_upper (cfg_wdata[ADDR_W-1:LOW_W]),
    .base_q   (base_q)
  );

  aid_match #(
    .MASK_W   (MASK_W),
    .EFF_MASK (EFF_MASK),
    .IS_IO    (IS_IO)
  ) u_match (
    .addr_upper (bus_addr[ADDR_W-1:LOW_W]),
    .base_q     (base_q),
    .bus_is_io  (bus_is_io),
    .mem_en     (mem_en),
    .io_en      (io_en),
    .hit        (hit)
  );

  aid_xlat #(
    .ADDR_W    (ADDR_W),
    .MASK_W    (MASK_W),
    .EFF_MASK  (EFF_MASK),
    .XLAT_EN   (XLAT_EN),
    .XLAT_BASE (XLAT_BASE)
  ) u_xlat (
    .addr_in  (bus_addr),
    .addr_out (xlat_addr)
  );

  always_comb begin
    if (IMAGE_ON) rd_word = {base_q, {(LOW_W-1){1'b0}}, IS_IO};
    else          rd_word = '0;
    cfg_rdata = cfg_rd ? rd_word : '0;
  end

  AST_HIT_TYPE_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |-> (bus_is_io == IS_IO)); // R7
  AST_HIT_SPACE_ON: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |-> (bus_is_io ? io_en : mem_en)); // R7
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !IMAGE_ON |-> (!hit && cfg_rdata == '0)); // R8
  AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |-> ((bus_addr & FULL_MASK) == ({base_q, {LOW_W{1'b0}}} & FULL_MASK))); // R6
  AST_XLAT_KEEPS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (xlat_addr & ~FULL_MASK) == (bus_addr & ~FULL_MASK)); // R11
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_rd |-> (cfg_rdata == '0)); // R12

  generate
    if (!XLAT_EN) begin : g_chk_pass
      AST_NO_XLAT_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
        xlat_addr == bus_addr); // R10
    end
  endgenerate
endmodule

// File: tb/sim_addr_image_decoder.sv
`timescale 1ns/1ps
module sim_addr_image_decoder;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [31:0] cfg_wdata;
  logic        cfg_rd;
  logic [31:0] bus_addr;
  logic        bus_is_io;
  logic        mem_en;
  logic        io_en;
  logic [31:0] rd0, rd1, rd2;
  logic [31:0] xa0, xa1, xa2;
  logic        hit0, hit1, hit2;

  int vectors;
  int miscompares;
  bit done;

  // u0: memory window, mask 0xFFFFF0 (4 KB), no translation
  addr_image_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rd(cfg_rd), .cfg_rdata(rd0), .bus_addr(bus_addr),
    .bus_is_io(bus_is_io), .mem_en(mem_en), .io_en(io_en),
    .hit(hit0), .xlat_addr(xa0)
  );

  // u1: I/O window, mask 0xFFF00F (low nibble below decode range), translation on
  addr_image_decoder #(
    .MASK(24'hFFF00F), .IS_IO(1'b1), .XLAT_EN(1'b1), .XLAT_BASE(24'hABCDEF)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rd(cfg_rd), .cfg_rdata(rd1), .bus_addr(bus_addr),
    .bus_is_io(bus_is_io), .mem_en(mem_en), .io_en(io_en),
    .hit(hit1), .xlat_addr(xa1)
  );

  // u2: mask entirely below decode range -> window off
  addr_image_decoder #(
    .MASK(24'h00000F), .XLAT_EN(1'b1), .XLAT_BASE(24'hFFFFFF)
  ) u2 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rd(cfg_rd), .cfg_rdata(rd2), .bus_addr(bus_addr),
    .bus_is_io(bus_is_io), .mem_en(mem_en), .io_en(io_en),
    .hit(hit2), .xlat_addr(xa2)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] d);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr    = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic read_all(output logic [31:0] r0, output logic [31:0] r1,
                          output logic [31:0] r2);
    @(negedge clk);
    cfg_rd = 1'b1;
    #1;
    r0 = rd0; r1 = rd1; r2 = rd2;
    cfg_rd = 1'b0;
  endtask

  task automatic drive_bus(input logic [31:0] a, input logic io,
                           input logic men, input logic ien);
    @(negedge clk);
    bus_addr  = a;
    bus_is_io = io;
    mem_en    = men;
    io_en     = ien;
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] r0, r1, r2;
    read_all(r0, r1, r2);
    check("R12", "u0 reset readback", r0, 32'h0000_0000);
    check("R4",  "u1 reset readback io bit", r1, 32'h0000_0001);
    check("R8",  "u2 reset readback", r2, 32'h0000_0000);
    drive_bus(32'h0000_0000, 1'b0, 1'b0, 1'b0);
    check("R7", "u0 no hit with mem_en low", {31'b0, hit0}, 32'h0);
    check("R12", "u1 rdata idle", rd1, 32'h0);
  endtask

  task automatic t_sizing;
    logic [31:0] r0, r1, r2;
    cfg_write(32'hFFFF_FFFF);
    read_all(r0, r1, r2);
    check("R3", "u0 sizing 4KB", r0, 32'hFFFF_F000);
    check("R1", "u0 size computed", (~(r0 & 32'hFFFF_FFF0)) + 32'd1, 32'h0000_1000);
    check("R2", "u1 sizing 1MB with dropped nibble", r1, 32'hFFF0_0001);
    check("R1", "u1 size computed", (~(r1 & 32'hFFFF_FFFC)) + 32'd1, 32'h0010_0000);
    check("R8", "u2 sizing reads zero", r2, 32'h0);
  endtask

  task automatic t_program;
    logic [31:0] r0, r1, r2;
    cfg_write(32'h1234_5678);
    read_all(r0, r1, r2);
    check("R5", "u0 unmasked bits dropped", r0, 32'h1234_5000);
    check("R5", "u1 unmasked bits dropped", r1, 32'h1230_0001);
    check("R8", "u2 still zero", r2, 32'h0);
  endtask

  task automatic t_window;
    drive_bus(32'h1234_5000, 1'b0, 1'b1, 1'b1);
    check("R6", "u0 hit low edge", {31'b0, hit0}, 32'h1);
    drive_bus(32'h1234_5FFF, 1'b0, 1'b1, 1'b1);
    check("R6", "u0 hit high edge", {31'b0, hit0}, 32'h1);
    drive_bus(32'h1234_6000, 1'b0, 1'b1, 1'b1);
    check("R6", "u0 miss above", {31'b0, hit0}, 32'h0);
    drive_bus(32'h1234_4FFF, 1'b0, 1'b1, 1'b1);
    check("R6", "u0 miss below", {31'b0, hit0}, 32'h0);
    drive_bus(32'h123F_FFFF, 1'b1, 1'b1, 1'b1);
    check("R2", "u1 hit ignores bits 11:8", {31'b0, hit1}, 32'h1);
    drive_bus(32'h1240_0000, 1'b1, 1'b1, 1'b1);
    check("R1", "u1 miss past 1MB", {31'b0, hit1}, 32'h0);
  endtask

  task automatic t_type_enable;
    drive_bus(32'h1234_5010, 1'b1, 1'b1, 1'b1);
    check("R7", "u0 miss on io access", {31'b0, hit0}, 32'h0);
    check("R7", "u1 hit on io access", {31'b0, hit1}, 32'h1);
    drive_bus(32'h1234_5010, 1'b0, 1'b0, 1'b1);
    check("R7", "u0 miss with mem_en low", {31'b0, hit0}, 32'h0);
    check("R7", "u1 miss on mem access", {31'b0, hit1}, 32'h0);
    drive_bus(32'h1234_5010, 1'b1, 1'b1, 1'b0);
    check("R7", "u1 miss with io_en low", {31'b0, hit1}, 32'h0);
    drive_bus(32'h0000_0000, 1'b0, 1'b1, 1'b1);
    check("R8", "u2 never hits", {31'b0, hit2}, 32'h0);
  endtask

  task automatic t_xlat;
    drive_bus(32'h123A_BCDE, 1'b1, 1'b1, 1'b1);
    check("R9", "u1 translated upper", xa1, 32'hABCA_BCDE);
    check("R11", "u1 low bits kept", xa1 & 32'h000F_FFFF, 32'h000A_BCDE);
    check("R10", "u0 passthrough", xa0, 32'h123A_BCDE);
    check("R11", "u2 nothing masked passes", xa2, 32'h123A_BCDE);
    drive_bus(32'hFEDC_BA98, 1'b0, 1'b1, 1'b1);
    check("R9", "u1 translated second pattern", xa1, 32'hABCC_BA98);
    check("R10", "u0 passthrough second", xa0, 32'hFEDC_BA98);
  endtask

  initial begin
    vectors = 0; miscompares = 0; done = 1'b0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; cfg_rd = 1'b0;
    bus_addr = '0; bus_is_io = 1'b0; mem_en = 1'b0; io_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sizing();
    t_program();
    t_window();
    t_type_enable();
    t_xlat();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule